// File: doc/BRIEF.md
# Link Training Clock-Recovery Sequencer

This block drives the clock-recovery phase of training for a two-lane serial display link on the transmit side. It talks to the sink's configuration space through a simple single-outstanding transaction port: each request carries a 20-bit address, a write flag and a data byte, and it stays up until the far side returns an acknowledge with a response code and, for reads, a data byte.

After a `start` pulse the sequencer programs the link rate, the lane count and training pattern 1. It then writes the drive setting of each lane and reads the training read-interval code. It waits that long using a cycle counter scaled by a clock-frequency parameter, then reads the lane status byte and the adjustment-request byte. When both lanes report lock it stops with `cr_done`. Otherwise it copies the requested swing and pre-emphasis into the next pair of lane writes and repeats. Two conditions end the loop as a failure: a pass at maximum swing that does not lock, or a swing request that stays the same for too long. On failure the block turns the training pattern off and raises `cr_fail`. A negative or timed-out response ends the run at once.

Top module: `lt_cr_seq`

## Requirements
- R1: After `start`, the first three transactions are writes, in this order: 0x0A to address 0x00100, 0x82 to 0x00101, and 0x21 to 0x00102.
- R2: The first pass writes 0x00 to lane 0 at address 0x00103 and then 0x00 to lane 1 at address 0x00104, meaning swing 0 and pre-emphasis 0. Lane bytes always have bits 7:6 at zero.
- R3: Each lane pair is followed by a read of 0x0000E. Code 0 gives a 100 µs wait, codes 1 to 4 give code×4 ms, and larger codes give 16 ms. After the wait the block reads 0x00202 and then 0x00206.
- R4: Lock means bit 0 (lane 0) and bit 4 (lane 1) of the status byte are both set. On lock the block raises `cr_done`, keeps `cr_fail` low and issues no further transaction. One lane alone does not count as lock.
- R5: In the request byte, lane 0 swing is bits 1:0 and its pre-emphasis bits 3:2; lane 1 uses bits 5:4 and 7:6. Each lane byte written next carries swing in bits 1:0, pre-emphasis in bits 4:3, bit 2 set when swing is 3 and bit 5 set when pre-emphasis is 3.
- R6: A pass whose applied swing is 3 on either lane and that does not lock ends the loop through the failure path.
- R7: If the requested swing equals the applied swing on both lanes for SAME_LIMIT passes in a row (default 5), the loop ends through the failure path.
- R8: The failure path writes 0x00 to address 0x00102, then raises `cr_fail` with `cr_done` low and issues nothing more.
- R9: An acknowledge whose response is not 0 (1 negative, 2 timeout) raises `cr_fail` at once, and no further transaction follows.
- R10: After reset, `txn_req`, `cr_done` and `cr_fail` are low. A `start` in idle clears both flags on the next clock.
- R11: A request holds its address, write flag and data stable until it is acknowledged. It drops on the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a training run when idle |
| txn_req | output | 1 | Transaction request, held until acknowledged |
| txn_wr | output | 1 | 1 = write, 0 = read |
| txn_addr | output | 20 | Configuration-space address |
| txn_wdata | output | 8 | Write data |
| txn_ack | input | 1 | One-cycle acknowledge of the pending request |
| txn_resp | input | 2 | Response code with the acknowledge: 0 ok, 1 negative, 2 timeout |
| txn_rdata | input | 8 | Read data with the acknowledge |
| cr_done | output | 1 | Clock recovery locked |
| cr_fail | output | 1 | Clock recovery given up or aborted |

## Verification
The loop is tried with four kinds of sink behaviour:
- **Rising swing requests with no lock.** The bench checks that each request is copied into the lane writes and that the run stops after the pass at maximum swing.
- **Status bytes that lock only one lane.** Pre-emphasis-only requests, including the maximum level, are mixed in. This tells partial lock from full lock and checks the pre-emphasis field and its flag.
- **A constant zero request with an out-of-range interval code.** This reaches the repeat limit and checks the clamped long wait.
- **A negative acknowledge on the second configuration write.** This separates the immediate abort from the orderly failure path, which turns the pattern off first.

// File: rtl/lt_cr_pkg.sv
package lt_cr_pkg;
  localparam int AW    = 20;
  localparam int DW    = 8;
  localparam int LANES = 2;

  localparam logic [AW-1:0] A_RATE  = 20'h00100;
  localparam logic [AW-1:0] A_LANES = 20'h00101;
  localparam logic [AW-1:0] A_PATT  = 20'h00102;
  localparam logic [AW-1:0] A_DRV0  = 20'h00103;
  localparam logic [AW-1:0] A_DRV1  = 20'h00104;
  localparam logic [AW-1:0] A_RDINT = 20'h0000E;
  localparam logic [AW-1:0] A_STAT  = 20'h00202;
  localparam logic [AW-1:0] A_ADJ   = 20'h00206;

  localparam logic [DW-1:0] V_RATE     = 8'h0A;
  localparam logic [DW-1:0] V_LANES    = 8'h82;
  localparam logic [DW-1:0] V_PATT     = 8'h21;
  localparam logic [DW-1:0] V_PATT_OFF = 8'h00;

  localparam logic [1:0] RSP_OK = 2'd0;

  typedef enum logic [3:0] {
    S_IDLE, S_RATE, S_LANES, S_PATT, S_DRV0, S_DRV1,
    S_RDINT, S_WAIT, S_STAT, S_ADJ, S_EVAL, S_OFF
  } seq_st_t;

  typedef struct packed {
    logic [1:0] pe;
    logic [1:0] sw;
  } drv_t;
endpackage

// File: rtl/lt_wait_timer.sv
module lt_wait_timer
  import lt_cr_pkg::*;
#(
  parameter int CLK_HZ   = 200_000_000,
  parameter int MAX_CODE = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] code,
  output logic          expired
);
  localparam int C_SHORT = CLK_HZ / 10_000;
  localparam int C_LONG  = CLK_HZ / 250;
  localparam int C_TOP   = MAX_CODE * C_LONG;
  localparam int CW      = $clog2(C_TOP + 2);

  logic [CW-1:0] cnt;
  logic          busy;

  function automatic logic [CW-1:0] span(input logic [DW-1:0] c);
    int n;
    if (c == '0)                 n = C_SHORT;
    else if (int'(c) > MAX_CODE) n = C_TOP;
    else                         n = int'(c) * C_LONG;
    if (n < 1) n = 1;
    return CW'(n);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      busy    <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (load) begin
        cnt  <= span(code);
        busy <= 1'b1;
      end else if (busy) begin
        if (cnt <= CW'(1)) begin
          busy    <= 1'b0;
          expired <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R3: expiry only ends a running wait
  a_r3_expire_after_busy: assert property (@(posedge clk) disable iff (rst)
    expired |-> $past(busy));
  // R3: a running wait counts down one per cycle
  a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
    (busy && !load && cnt > CW'(1)) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/lt_drive_map.sv
module lt_drive_map
  import lt_cr_pkg::*;
(
  input  logic [DW-1:0]         adj,
  input  drv_t [LANES-1:0]      cur,
  output drv_t [LANES-1:0]      want,
  output logic [DW*LANES-1:0]   lane_bytes
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign want[g] = {adj[4*g+2 +: 2], adj[4*g +: 2]};
    assign lane_bytes[DW*g +: DW] = {2'b00, &cur[g].pe, cur[g].pe,
                                     &cur[g].sw, cur[g].sw};
  end
endmodule

// File: rtl/lt_cr_judge.sv
module lt_cr_judge
  import lt_cr_pkg::*;
(
  input  logic [LANES-1:0] lane_ok,
  input  drv_t [LANES-1:0] cur,
  input  drv_t [LANES-1:0] want,
  output logic             lock,
  output logic             at_max,
  output logic             same
);
  logic [LANES-1:0] lane_max, lane_same;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_max[g]  = (cur[g].sw == 2'd3);
    assign lane_same[g] = (want[g].sw == cur[g].sw);
  end

  assign lock   = &lane_ok;
  assign at_max = |lane_max;
  assign same   = &lane_same;
endmodule

// File: rtl/lt_cr_seq.sv
module lt_cr_seq
  import lt_cr_pkg::*;
#(
  parameter int CLK_HZ     = 200_000_000,
  parameter int SAME_LIMIT = 5,
  parameter int MAX_CODE   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          txn_req,
  output logic          txn_wr,
  output logic [AW-1:0] txn_addr,
  output logic [DW-1:0] txn_wdata,
  input  logic          txn_ack,
  input  logic [1:0]    txn_resp,
  input  logic [DW-1:0] txn_rdata,
  output logic          cr_done,
  output logic          cr_fail
);
  localparam int SCW = $clog2(SAME_LIMIT + 1);

  seq_st_t              st;
  drv_t [LANES-1:0]     cur, want;
  logic [LANES-1:0]     lane_ok;
  logic [DW-1:0]        adj_q;
  logic [SCW-1:0]       same_cnt;
  logic [DW*LANES-1:0]  lane_bytes;
  logic                 lock, at_max, same;
  logic                 acc, ok, bad, tmr_load, tmr_exp;
  logic                 is_txn, t_wr;
  logic [AW-1:0]        t_addr;
  logic [DW-1:0]        t_data;

  assign acc      = txn_req & txn_ack;
  assign ok       = acc & (txn_resp == RSP_OK);
  assign bad      = acc & (txn_resp != RSP_OK);
  assign tmr_load = (st == S_RDINT) & ok;

  lt_wait_timer #(.CLK_HZ(CLK_HZ), .MAX_CODE(MAX_CODE)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .code(txn_rdata), .expired(tmr_exp)
  );

  lt_drive_map u_map (
    .adj(adj_q), .cur(cur), .want(want), .lane_bytes(lane_bytes)
  );

  lt_cr_judge u_judge (
    .lane_ok(lane_ok), .cur(cur), .want(want),
    .lock(lock), .at_max(at_max), .same(same)
  );

  // transaction carried by each state
  always_comb begin
    is_txn = 1'b1;
    t_wr   = 1'b1;
    t_addr = '0;
    t_data = '0;
    unique case (st)
      S_RATE:  begin t_addr = A_RATE;  t_data = V_RATE;  end
      S_LANES: begin t_addr = A_LANES; t_data = V_LANES; end
      S_PATT:  begin t_addr = A_PATT;  t_data = V_PATT;  end
      S_DRV0:  begin t_addr = A_DRV0;  t_data = lane_bytes[DW-1:0]; end
      S_DRV1:  begin t_addr = A_DRV1;  t_data = lane_bytes[2*DW-1:DW]; end
      S_RDINT: begin t_addr = A_RDINT; t_wr = 1'b0; end
      S_STAT:  begin t_addr = A_STAT;  t_wr = 1'b0; end
      S_ADJ:   begin t_addr = A_ADJ;   t_wr = 1'b0; end
      S_OFF:   begin t_addr = A_PATT;  t_data = V_PATT_OFF; end
      default: begin is_txn = 1'b0; t_wr = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      txn_req   <= 1'b0;
      txn_wr    <= 1'b0;
      txn_addr  <= '0;
      txn_wdata <= '0;
      cr_done   <= 1'b0;
      cr_fail   <= 1'b0;
      cur       <= '0;
      lane_ok   <= '0;
      adj_q     <= '0;
      same_cnt  <= '0;
    end else begin
      if (is_txn && !txn_req) begin
        txn_req   <= 1'b1;
        txn_wr    <= t_wr;
        txn_addr  <= t_addr;
        txn_wdata <= t_data;
      end
      if (acc) txn_req <= 1'b0;

      if (bad) begin
        cr_fail <= 1'b1;
        st      <= S_IDLE;
      end else begin
        unique case (st)
          S_IDLE: if (start) begin
            cr_done  <= 1'b0;
            cr_fail  <= 1'b0;
            cur      <= '0;
            same_cnt <= '0;
            st       <= S_RATE;
          end
          S_RATE:  if (ok) st <= S_LANES;
          S_LANES: if (ok) st <= S_PATT;
          S_PATT:  if (ok) st <= S_DRV0;
          S_DRV0:  if (ok) st <= S_DRV1;
          S_DRV1:  if (ok) st <= S_RDINT;
          S_RDINT: if (ok) st <= S_WAIT;
          S_WAIT:  if (tmr_exp) st <= S_STAT;
          S_STAT:  if (ok) begin
            lane_ok <= {txn_rdata[4], txn_rdata[0]};
            st      <= S_ADJ;
          end
          S_ADJ:   if (ok) begin
            adj_q <= txn_rdata;
            st    <= S_EVAL;
          end
          S_EVAL: begin
            if (lock) begin
              cr_done <= 1'b1;
              st      <= S_IDLE;
            end else if (at_max) begin
              st <= S_OFF;
            end else if (same && same_cnt == SCW'(SAME_LIMIT - 1)) begin
              st <= S_OFF;
            end else begin
              cur      <= want;
              same_cnt <= same ? same_cnt + 1'b1 : '0;
              st       <= S_DRV0;
            end
          end
          S_OFF: if (ok) begin
            cr_fail <= 1'b1;
            st      <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R11: request and its fields hold until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (txn_req && !txn_ack) |=> (txn_req && $stable(txn_addr) &&
                               $stable(txn_wdata) && $stable(txn_wr)));
  // R11: request drops right after its acknowledge
  a_r11_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (txn_req && txn_ack) |=> !txn_req);
  // R4: done and fail never together
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    cr_done |-> !cr_fail);
  // R4: no traffic once locked
  a_r4_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
    cr_done |-> !txn_req);
  // R9: no traffic once failed
  a_r9_quiet_when_failed: assert property (@(posedge clk) disable iff (rst)
    cr_fail |-> !txn_req);
  // R2: lane bytes keep their top bits clear
  a_r2_lane_byte_top: assert property (@(posedge clk) disable iff (rst)
    (txn_req && txn_wr && (txn_addr == A_DRV0 || txn_addr == A_DRV1))
      |-> (txn_wdata[7:6] == 2'b00));
endmodule

// File: tb/lt_cr_seq_test.sv
`timescale 1ns/1ps
module lt_cr_seq_test;
  localparam int CLK_HZ = 1_000_000;
  localparam int C_SHORT = CLK_HZ / 10_000;
  localparam int C_LONG = CLK_HZ / 250;
  localparam int WD_LIMIT = 190_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic txn_req, txn_wr, txn_ack, cr_done, cr_fail;
  logic [19:0] txn_addr;
  logic [7:0] txn_wdata, txn_rdata;
  logic [1:0] txn_resp;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  logic [28:0] exp_q[$];
  string tag_q[$];
  logic [7:0] stat_q[$];
  logic [7:0] adj_q[$];
  logic [7:0] int_code = 8'h00;
  int nack_at = -1;
  int tx_idx = 0;
  int dly = 0;
  int t_int = -1;
  logic [28:0] got, e;
  string t;

  always #2.5 clk = ~clk;

  lt_cr_seq #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst(rst), .start(start),
    .txn_req(txn_req), .txn_wr(txn_wr), .txn_addr(txn_addr),
    .txn_wdata(txn_wdata), .txn_ack(txn_ack), .txn_resp(txn_resp),
    .txn_rdata(txn_rdata), .cr_done(cr_done), .cr_fail(cr_fail)
  );

  task automatic check(input bit good, input string tg,
                       input logic [31:0] act, input logic [31:0] exv);
    vectors++;
    if (!good) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exv);
    end
  endtask

  function automatic int wait_len(input logic [7:0] c);
    if (c == 0) return C_SHORT;
    if (c > 4) return 4 * C_LONG;
    return int'(c) * C_LONG;
  endfunction

  // driver side of the scoreboard
  task automatic push_w(input logic [19:0] a, input logic [7:0] d, input string tg);
    exp_q.push_back({1'b1, a, d});
    tag_q.push_back(tg);
  endtask

  task automatic push_r(input logic [19:0] a, input string tg);
    exp_q.push_back({1'b0, a, 8'h00});
    tag_q.push_back(tg);
  endtask

  task automatic push_cfg();
    push_w(20'h00100, 8'h0A, "R1");
    push_w(20'h00101, 8'h82, "R1");
    push_w(20'h00102, 8'h21, "R1");
  endtask

  task automatic push_pass(input logic [7:0] l0, input logic [7:0] l1, input string tg);
    push_w(20'h00103, l0, tg);
    push_w(20'h00104, l1, tg);
    push_r(20'h0000E, "R3");
    push_r(20'h00202, "R3");
    push_r(20'h00206, "R3");
  endtask

  // monitor and sink model: acknowledges two cycles after a request
  always @(negedge clk) begin
    txn_ack = 1'b0;
    if (rst) begin
      dly = 0;
    end else if (txn_req) begin
      if (dly == 0 && txn_addr == 20'h00202 && t_int >= 0) begin
        check((cyc - t_int) >= wait_len(int_code) + 2 &&
              (cyc - t_int) <= wait_len(int_code) + 4,
              "R3 wait", cyc - t_int, wait_len(int_code) + 3);
        t_int = -1;
      end
      dly++;
      if (dly == 2) begin
        dly = 0;
        got = {txn_wr, txn_addr, txn_wr ? txn_wdata : 8'h00};
        if (exp_q.size() == 0) begin
          check(1'b0, "R4/R9 unexpected transaction", {3'b0, got}, 32'h0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(got == e, t, {3'b0, got}, {3'b0, e});
        end
        txn_rdata = 8'h00;
        if (!txn_wr && txn_addr == 20'h0000E) begin
          txn_rdata = int_code;
          t_int = cyc;
        end else if (!txn_wr && txn_addr == 20'h00202 && stat_q.size() > 0) begin
          txn_rdata = stat_q.pop_front();
        end else if (!txn_wr && txn_addr == 20'h00206 && adj_q.size() > 0) begin
          txn_rdata = adj_q.pop_front();
        end
        txn_resp = (tx_idx == nack_at) ? 2'd1 : 2'd0;
        txn_ack = 1'b1;
        tx_idx++;
      end
    end else if (dly != 0) begin
      check(1'b0, "R11 request dropped before ack", 32'd0, 32'd1);
      dly = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic run(input bit want_done, input string tg);
    tx_idx = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(!cr_done && !cr_fail, "R10 start clears flags", {cr_done, cr_fail}, 0);
    while (!(cr_done || cr_fail)) @(negedge clk);
    repeat (20) @(negedge clk);
    check(cr_done == want_done && cr_fail == !want_done, tg,
          {cr_done, cr_fail}, {want_done, !want_done});
    check(exp_q.size() == 0, {tg, " all transactions seen"}, exp_q.size(), 0);
    check(!txn_req, {tg, " quiet after end"}, txn_req, 0);
  endtask

  initial begin
    txn_ack = 1'b0;
    txn_resp = 2'd0;
    txn_rdata = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!txn_req && !cr_done && !cr_fail, "R10 reset state",
          {txn_req, cr_done, cr_fail}, 0);

    // rising swing requests, never locking: stop after the swing-3 pass
    int_code = 8'h00;
    stat_q = '{8'h00, 8'h00, 8'h00, 8'h00};
    adj_q  = '{8'h11, 8'h22, 8'h33, 8'h33};
    push_cfg();
    push_pass(8'h00, 8'h00, "R2");
    push_pass(8'h01, 8'h01, "R5");
    push_pass(8'h02, 8'h02, "R5");
    push_pass(8'h07, 8'h07, "R5 swing max flag");
    push_w(20'h00102, 8'h00, "R6 R8 pattern off");
    run(1'b0, "R6 fail at max swing");

    // one-lane status, pre-emphasis requests, then full lock
    int_code = 8'h01;
    stat_q = '{8'h01, 8'h10, 8'h11};
    adj_q  = '{8'h94, 8'hC4, 8'h00};
    push_cfg();
    push_pass(8'h00, 8'h00, "R2");
    push_pass(8'h08, 8'h11, "R5");
    push_pass(8'h08, 8'h38, "R5 pre-emphasis max flag");
    run(1'b1, "R4 lock");

    // constant request: repeat limit, clamped long wait
    int_code = 8'h07;
    stat_q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    adj_q  = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    push_cfg();
    for (int i = 0; i < 5; i++) push_pass(8'h00, 8'h00, "R7");
    push_w(20'h00102, 8'h00, "R8 pattern off");
    run(1'b0, "R7 repeat limit");

    // negative acknowledge on the second write aborts at once
    nack_at = 1;
    push_w(20'h00100, 8'h0A, "R1");
    push_w(20'h00101, 8'h82, "R9");
    run(1'b0, "R9 abort on nack");
    nack_at = -1;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule